// File: doc/BRIEF.md
# Active-Window Crop Timing Generator

This block frames the active region of a decoded video stream. It runs at pixel rate, counts qualified pixels from the end of each horizontal reset strobe and counts lines from the end of each vertical reset strobe. It raises a horizontal-active flag, a vertical-active flag and a combined per-pixel active qualifier while the current pixel falls inside a programmed window. The vertical offset is measured in half-lines and depends on the field parity. Downstream scaling or capture logic uses the qualifier to decide which pixels to keep.

The window is set by four 10-bit values: vertical delay, vertical size, horizontal delay and horizontal size. Each value has its own low-byte register. The two upper bits of all four values share one crop register. A microprocessor can read or write every register at any time. The counting logic does not use the registers directly. It uses shadow copies. Horizontal values are copied only while the horizontal reset is high, and vertical values only while the vertical reset is high, so a window never changes partway through a line or a field.

Top module: `crop_window_gen`

## Requirements
- R1: After reset the registers read back as follows. Address 0 (vertical delay low) reads 0x16, address 1 (vertical size low) reads 0xE0, address 2 (horizontal delay low) reads 0x78, address 3 (horizontal size low) reads 0x80 and address 4 (crop) reads 0x12. Addresses 5 to 7 read 0. The read data is combinational from `reg_addr`.
- R2: A byte written with `reg_we` high to address 0 to 4 can be read back from the cycle after the write, at any time. Writes to addresses 5 to 7 have no effect.
- R3: The crop register holds bits [9:8] of each value: vertical delay in [7:6], vertical size in [5:4], horizontal delay in [3:2] and horizontal size in [1:0]. Its reset value gives a vertical size of 480 and a horizontal size of 640.
- R4: Bit 0 of the horizontal delay is treated as 0. An odd programmed delay D opens the window at pixel count D-1.
- R5: `pix_cnt` is 0 in the cycle after any cycle where `hrst` is high. After that it increases by 1 for each cycle where `pix_valid` is high, and it saturates at 1023.
- R6: `h_active` is high when `hrst` is low and E <= `pix_cnt` < E + HS. Here E is the even horizontal delay and HS is the horizontal size.
- R7: `line_cnt` is 0 in the cycle after any cycle where `vrst` is high. After that it increases by 1 after each falling edge of `hrst`, and it saturates at 1023.
- R8: The half-line position is 2*`line_cnt` + 1 for an even field and 2*`line_cnt` for an odd field. The parity is `field_odd` as sampled while `vrst` is high. `v_active` is high when `vrst` is low and VD <= position < VD + 2*VS.
- R9: New horizontal register values take effect only through a cycle where `hrst` is high. New vertical register values and the field parity take effect only through a cycle where `vrst` is high. A write made in the same cycle as the copy is not seen until the next copy.
- R10: `active` is high exactly when `h_active`, `v_active` and `pix_valid` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel qualifier for this cycle |
| hrst | input | 1 | Horizontal reset strobe, active high |
| vrst | input | 1 | Vertical reset strobe, active high |
| field_odd | input | 1 | Field parity, 1 for an odd field |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| h_active | output | 1 | Inside the horizontal window |
| v_active | output | 1 | Inside the vertical window |
| active | output | 1 | Combined active-pixel qualifier |
| line_cnt | output | 10 | Lines since the end of the vertical reset |
| pix_cnt | output | 10 | Valid pixels since the end of the horizontal reset |

## Verification
A register write and a shadow copy can happen in the same cycle. The bench provokes this by writing a low-byte or crop register while `hrst` or `vrst` is high. The reference model then expects the shadow to keep the old value until the next strobe. A falling edge of `hrst` can also coincide with a high `vrst`. Here the model expects the line counter to stay cleared rather than advance. Random traffic mixes both cases with random pixel-valid patterns, and every output is compared against the model each clock.

// File: rtl/crop_window_gen.sv
module crop_window_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_valid,
  input  logic       hrst,
  input  logic       vrst,
  input  logic       field_odd,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       h_active,
  output logic       v_active,
  output logic       active,
  output logic [9:0] line_cnt,
  output logic [9:0] pix_cnt
);
  localparam int CW = 10;
  localparam logic [CW-1:0] CMAX = '1;

  logic [7:0] vdly_lo, vsz_lo, hdly_lo, hsz_lo, crop;
  logic [CW-1:0] hdly_s, hsz_s, vdly_s, vsz_s;
  logic [CW-1:0] pix_q, line_q;
  logic hrst_q, fld_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vdly_lo <= 8'h16;
      vsz_lo  <= 8'hE0;
      hdly_lo <= 8'h78;
      hsz_lo  <= 8'h80;
      crop    <= 8'h12;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: vdly_lo <= reg_wdata;
        3'd1: vsz_lo  <= reg_wdata;
        3'd2: hdly_lo <= reg_wdata;
        3'd3: hsz_lo  <= reg_wdata;
        3'd4: crop    <= reg_wdata;
        default: ;
      endcase
    end

  always_comb
    case (reg_addr)
      3'd0: reg_rdata = vdly_lo;
      3'd1: reg_rdata = vsz_lo;
      3'd2: reg_rdata = hdly_lo;
      3'd3: reg_rdata = hsz_lo;
      3'd4: reg_rdata = crop;
      default: reg_rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hdly_s <= 10'h078;
      hsz_s  <= 10'h280;
    end else if (hrst) begin
      hdly_s <= {crop[3:2], hdly_lo};
      hsz_s  <= {crop[1:0], hsz_lo};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vdly_s <= 10'h016;
      vsz_s  <= 10'h1E0;
      fld_q  <= 1'b0;
    end else if (vrst) begin
      vdly_s <= {crop[7:6], vdly_lo};
      vsz_s  <= {crop[5:4], vsz_lo};
      fld_q  <= field_odd;
    end

  wire hfall = hrst_q & ~hrst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hrst_q <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      hrst_q <= hrst;
      if (hrst) pix_q <= '0;
      else if (pix_valid && pix_q != CMAX) pix_q <= pix_q + 1'b1;
      if (vrst) line_q <= '0;
      else if (hfall && line_q != CMAX) line_q <= line_q + 1'b1;
    end

  wire [CW-1:0] hstart = {hdly_s[CW-1:1], 1'b0};
  wire [CW:0]   hstop  = {1'b0, hstart} + {1'b0, hsz_s};
  wire [CW+1:0] vpos   = {1'b0, line_q, ~fld_q};
  wire [CW+1:0] vstart = {2'b00, vdly_s};
  wire [CW+1:0] vstop  = vstart + {1'b0, vsz_s, 1'b0};

  assign h_active = ~hrst & (pix_q >= hstart) & ({1'b0, pix_q} < hstop);
  assign v_active = ~vrst & (vpos >= vstart) & (vpos < vstop);
  assign active   = h_active & v_active & pix_valid;
  assign line_cnt = line_q;
  assign pix_cnt  = pix_q;
endmodule

module crop_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hrst,
  input logic       vrst,
  input logic       h_active,
  input logic [9:0] pix_cnt,
  input logic [9:0] line_cnt
);
  AST_PIX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) hrst |=> pix_cnt == 10'd0); // R5
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n) !hrst |=> (pix_cnt == $past(pix_cnt)) || (pix_cnt == $past(pix_cnt) + 10'd1)); // R5
  AST_EVEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(h_active) |-> pix_cnt[0] == 1'b0); // R4
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) vrst |=> line_cnt == 10'd0); // R7
  AST_LINE_MONO: assert property (@(posedge clk) disable iff (!rst_n) !vrst |=> line_cnt >= $past(line_cnt)); // R7
endmodule

bind crop_window_gen crop_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hrst(hrst), .vrst(vrst),
  .h_active(h_active), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
);

// File: tb/tb_crop_window_gen.sv
`timescale 1ns/1ps
module tb_crop_window_gen;
  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, hrst = 0, vrst = 0, field_odd = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic h_active, v_active, active;
  logic [9:0] line_cnt, pix_cnt;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crop_window_gen dut (.*);

  int regs [5];
  int m_hdly, m_hsz, m_vdly, m_vsz, m_pix, m_line;
  bit m_hq, m_fld;

  task automatic fail(string req, string sig, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
  endtask

  task automatic compare();
    int hs, pos, rd;
    bit eh, ev, ea;
    hs  = (m_hdly / 2) * 2;
    eh  = !hrst && m_pix >= hs && m_pix < hs + m_hsz;
    pos = 2 * m_line + (m_fld ? 0 : 1);
    ev  = !vrst && pos >= m_vdly && pos < m_vdly + 2 * m_vsz;
    ea  = eh && ev && pix_valid;
    rd  = reg_addr < 5 ? regs[reg_addr] : 0;
    vectors++;
    if (reg_rdata !== rd[7:0]) fail("R1 R2 R3", "reg_rdata", reg_rdata, rd);
    if (pix_cnt !== m_pix[9:0]) fail("R5", "pix_cnt", pix_cnt, m_pix);
    if (h_active !== eh) fail("R4 R6 R9", "h_active", h_active, eh);
    if (line_cnt !== m_line[9:0]) fail("R7", "line_cnt", line_cnt, m_line);
    if (v_active !== ev) fail("R8 R9", "v_active", v_active, ev);
    if (active !== ea) fail("R10", "active", active, ea);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      regs = '{'h16, 'hE0, 'h78, 'h80, 'h12};
      m_hdly = 'h078; m_hsz = 'h280; m_vdly = 'h016; m_vsz = 'h1E0;
      m_pix = 0; m_line = 0; m_hq = 0; m_fld = 0;
    end else begin
      if (hrst) begin
        m_hdly = ((regs[4] >> 2) & 3) * 256 + regs[2];
        m_hsz  = (regs[4] & 3) * 256 + regs[3];
      end
      if (vrst) begin
        m_vdly = ((regs[4] >> 6) & 3) * 256 + regs[0];
        m_vsz  = ((regs[4] >> 4) & 3) * 256 + regs[1];
        m_fld  = field_odd;
      end
      if (vrst) m_line = 0;
      else if (m_hq && !hrst && m_line < 1023) m_line++;
      m_hq = hrst;
      if (hrst) m_pix = 0;
      else if (pix_valid && m_pix < 1023) m_pix++;
      if (reg_we && reg_addr < 5) regs[reg_addr] = reg_wdata;
    end
    #2;
    if (!done) compare();
  end

  // pattern: 0 all valid, 1 alternate, 2 random
  int pend_at = -1;
  logic [2:0] pend_addr;
  logic [7:0] pend_data;

  task automatic run_line(int len, int hlen, bit v, int pat);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hrst = (i < hlen);
      vrst = v;
      pix_valid = (pat == 0) ? 1'b1 : (pat == 1) ? i[0] : 1'($urandom);
      reg_we = (i == pend_at);
      if (i == pend_at) begin reg_addr = pend_addr; reg_wdata = pend_data; pend_at = -1; end
    end
  endtask

  task automatic frame(int lines, int len, bit odd, int pat);
    field_odd = odd;
    run_line(len, 2, 1, pat);
    run_line(len, 2, 1, pat);
    for (int l = 0; l < lines; l++) run_line(len, 2, 0, pat);
  endtask

  task automatic wr_at(int at, logic [2:0] a, logic [7:0] d);
    pend_at = at; pend_addr = a; pend_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset readback across all addresses
    for (int a = 0; a < 8; a++) begin @(negedge clk); reg_addr = 3'(a); end
    // R3 R6 R8: default window with short lines
    frame(14, 140, 0, 0);
    // R2 R9: mid-line writes, the old window stays until the strobes
    wr_at(20, 3'd0, 8'd3);  run_line(30, 2, 0, 0);
    wr_at(20, 3'd1, 8'd4);  run_line(30, 2, 0, 0);
    wr_at(1, 3'd2, 8'd5);   run_line(30, 2, 0, 0);  // write during hrst, R9
    wr_at(20, 3'd3, 8'd8);  run_line(30, 2, 0, 0);
    wr_at(20, 3'd4, 8'h00); run_line(30, 2, 0, 0);
    wr_at(20, 3'd6, 8'hFF); run_line(30, 2, 0, 0);  // ignored address, R2
    for (int a = 0; a < 8; a++) begin @(negedge clk); reg_addr = 3'(a); end
    // R4 R8: odd delay, both parities, varied valid patterns
    frame(12, 30, 0, 0);
    frame(12, 30, 1, 0);
    frame(12, 30, 1, 1);
    frame(12, 30, 0, 2);
    // R8: odd vertical delay separates the parities
    wr_at(3, 3'd0, 8'd7); run_line(30, 2, 0, 0);
    frame(10, 30, 0, 0);
    frame(10, 30, 1, 0);
    // R3: upper bits through the crop register
    wr_at(3, 3'd4, 8'b0101_0000); run_line(30, 2, 0, 0);
    frame(4, 30, 0, 0);
    wr_at(3, 3'd4, 8'h00); run_line(30, 2, 0, 0);
    // R5: pixel counter saturation
    run_line(1100, 2, 0, 0);
    // R7: line counter saturation
    frame(1030, 3, 0, 0);
    // R6: zero horizontal size never opens
    wr_at(3, 3'd3, 8'd0); run_line(30, 2, 0, 0);
    frame(8, 30, 0, 0);
    // mixed random traffic with coinciding writes and strobes
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      hrst = ($urandom % 12) == 0;
      vrst = ($urandom % 150) == 0;
      field_odd = 1'($urandom);
      pix_valid = 1'($urandom);
      reg_we = ($urandom % 8) == 0;
      reg_addr = 3'($urandom % 6);
      reg_wdata = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
      if (reg_addr == 3'd4) reg_wdata = 8'($urandom) & 8'h55;
    end
    @(negedge clk); reg_we = 0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule